// File: doc/BRIEF.md
# Compensated Timestamp Counter

This block keeps a free-running timestamp that only counts up. On every timer clock it adds a small programmable step to its count. Software sets the step through a 32-bit register port and reads the count, in two halves, through the same port or from the full-width count output.

Drift against a reference clock is corrected by compensation. Software loads a number of correction events, and for each event the counter adds a second programmable step in place of the normal one. In slow mode the correction events are spread out: a correction step is applied only once per programmed period, and every other edge uses the normal step.

A sticky overflow flag records a wrap of the count. Software clears it by writing one. A compare hit from outside can restart the count at a programmable value.

Top module: `tsc_counter`

## Requirements
- R1: After reset the count is 0, the overflow flag (address 3, bit 0) is 0, the remaining correction count (address 1) is 0, and the configuration (address 0) reads 0x004.
- R2: The configuration register at address 0 holds four fields. Bits [3:0] hold the normal step minus one. Bits [7:4] hold the correction step minus one. Bit 8 selects slow mode. Bit 9 enables the compare-hit restart. With no correction pending, each clock edge adds the normal step (1 to 16) to the count.
- R3: A write to address 1 loads the 24-bit remaining correction count. In normal mode, while that count is nonzero, each edge adds the correction step instead of the normal step and lowers the remaining count by one.
- R4: When the remaining correction count reaches zero, the counter goes back to the normal step, and address 1 reads 0.
- R5: In slow mode with period P (address 2, 24 bits), the correction step is applied on the P-th, 2P-th, and so on edges after the correction count is loaded. A period of 0 or 1 means every edge. Only those edges lower the remaining count, and all other edges add the normal step.
- R6: When adding the step carries out of the 64-bit count, the count wraps and the overflow flag is set.
- R7: Writing 1 to address 3 bit 0 clears the overflow flag. Writing 0 leaves it unchanged. If a wrap happens on the same edge as a clearing write, the flag stays set.
- R8: Addresses 4 and 5 hold the low and high halves of the restart value. When bit 9 of the configuration is set and cmp0_hit is high at an edge, the count takes the restart value at that edge in place of the step. When bit 9 is clear, cmp0_hit has no effect.
- R9: Addresses 6 and 7 read the low and high halves of the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| cmp0_hit | input | 1 | Compare-hit restart request |
| cnt | output | 64 | Current count |

## Verification
The checker tests several relations on every cycle. Between edges the count rises by 1 to 16 unless there is a restart or a wrap. The count lands exactly on the restart value after an enabled hit, and a decrease without a restart always raises the overflow flag. The remaining correction count only stays put or drops by one, and the flag survives any edge without a clearing write. Other properties need the bench's scenarios to show them. These are the exact sums over a window for each step and period combination, the placement of slow-mode corrections, the same-edge precedence of a wrap over a clear, and the ignored hit when restart is disabled.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam int INC_W = 4;

   typedef enum logic [2:0] {
      A_CFG  = 3'd0,
      A_CCNT = 3'd1,
      A_SPER = 3'd2,
      A_STAT = 3'd3,
      A_RLO  = 3'd4,
      A_RHI  = 3'd5,
      A_CLO  = 3'd6,
      A_CHI  = 3'd7
   } tsc_addr_e;

   typedef struct packed {
      logic             rst_en;
      logic             slow;
      logic [INC_W-1:0] cinc_m1;
      logic [INC_W-1:0] inc_m1;
   } tsc_cfg_t;

   localparam int CFG_W = $bits(tsc_cfg_t);
endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
   import tsc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 64,
   parameter int CCNT_W  = 24,
   parameter int INC_RST = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output tsc_cfg_t          cfg,
   output logic [CCNT_W-1:0] period,
   output logic [CNT_W-1:0]  rst_val,
   output logic              comp_ld,
   output logic [CCNT_W-1:0] comp_val,
   output logic              ovf_clr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              ovf,
   input  logic [CCNT_W-1:0] rem
);
   localparam tsc_cfg_t CFG_RST = '{rst_en: 1'b0, slow: 1'b0, cinc_m1: '0,
                                    inc_m1: INC_W'(INC_RST - 1)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= CFG_RST;
         period  <= '0;
         rst_val <= '0;
      end else if (wr_en) begin
         case (tsc_addr_e'(wr_addr))
            A_CFG:   cfg <= tsc_cfg_t'(wr_data[CFG_W-1:0]);
            A_SPER:  period <= wr_data[CCNT_W-1:0];
            A_RLO:   rst_val[DATA_W-1:0] <= wr_data;
            A_RHI:   rst_val[CNT_W-1:DATA_W] <= wr_data;
            default: ;
         endcase
      end
   end

   assign comp_ld  = wr_en && (tsc_addr_e'(wr_addr) == A_CCNT);
   assign comp_val = wr_data[CCNT_W-1:0];
   assign ovf_clr  = wr_en && (tsc_addr_e'(wr_addr) == A_STAT) && wr_data[0];

   always_comb begin
      rd_data = '0;
      case (tsc_addr_e'(rd_addr))
         A_CFG:  rd_data = {{(DATA_W-CFG_W){1'b0}}, cfg};
         A_CCNT: rd_data = {{(DATA_W-CCNT_W){1'b0}}, rem};
         A_SPER: rd_data = {{(DATA_W-CCNT_W){1'b0}}, period};
         A_STAT: rd_data = {{(DATA_W-1){1'b0}}, ovf};
         A_RLO:  rd_data = rst_val[DATA_W-1:0];
         A_RHI:  rd_data = rst_val[CNT_W-1:DATA_W];
         A_CLO:  rd_data = cnt[DATA_W-1:0];
         A_CHI:  rd_data = cnt[CNT_W-1:DATA_W];
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/tsc_comp.sv
module tsc_comp
   import tsc_pkg::*;
#(
   parameter int CCNT_W  = 24,
   parameter bit SLOW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tsc_cfg_t          cfg,
   input  logic [CCNT_W-1:0] period,
   input  logic              comp_ld,
   input  logic [CCNT_W-1:0] comp_val,
   output logic [INC_W:0]    step,
   output logic [CCNT_W-1:0] rem
);
   logic [CCNT_W-1:0] rem_q;
   logic              active;
   logic              gate;
   logic              apply;

   assign active = (rem_q != '0);

   generate
      if (SLOW_EN) begin : g_slow
         logic [CCNT_W-1:0] sctr_q;
         logic              tick;
         assign tick = (period <= CCNT_W'(1)) || (sctr_q == period - CCNT_W'(1));
         assign gate = !cfg.slow || tick;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         sctr_q <= '0;
            else if (comp_ld || !active || !cfg.slow) sctr_q <= '0;
            else if (tick)                      sctr_q <= '0;
            else                                sctr_q <= sctr_q + CCNT_W'(1);
         end
      end else begin : g_fast
         logic unused_slow;
         assign unused_slow = ^{period, cfg.slow};
         assign gate = 1'b1;
      end
   endgenerate

   assign apply = active && gate;
   assign step  = apply ? ({1'b0, cfg.cinc_m1} + (INC_W+1)'(1))
                        : ({1'b0, cfg.inc_m1} + (INC_W+1)'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rem_q <= '0;
      else if (comp_ld) rem_q <= comp_val;
      else if (apply)   rem_q <= rem_q - CCNT_W'(1);
   end

   assign rem = rem_q;
endmodule

// File: rtl/tsc_core.sv
module tsc_core #(
   parameter int CNT_W  = 64,
   parameter int STEP_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STEP_W-1:0] step,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_val,
   input  logic              ovf_clr,
   output logic [CNT_W-1:0]  cnt,
   output logic              ovf
);
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic [CNT_W:0]   sum;

   assign sum = {1'b0, cnt_q} + (CNT_W+1)'(step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         cnt_q <= load ? load_val : sum[CNT_W-1:0];
         ovf_q <= (ovf_q && !ovf_clr) || (sum[CNT_W] && !load);
      end
   end

   assign cnt = cnt_q;
   assign ovf = ovf_q;
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter
   import tsc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 64,
   parameter int CCNT_W  = 24,
   parameter int INC_RST = 5,
   parameter bit SLOW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cmp0_hit,
   output logic [CNT_W-1:0]  cnt
);
   localparam int STEP_W = INC_W + 1;

   initial begin
      assert (CNT_W == 2 * DATA_W) else $error("count must be two data words wide");
      assert (DATA_W > CCNT_W && DATA_W >= CFG_W) else $error("data word too narrow");
      assert (INC_RST >= 1 && INC_RST <= (1 << INC_W)) else $error("bad default step");
   end

   tsc_cfg_t          cfg;
   logic [CCNT_W-1:0] period;
   logic [CNT_W-1:0]  rst_val;
   logic              comp_ld;
   logic [CCNT_W-1:0] comp_val;
   logic              ovf_clr;
   logic              ovf;
   logic [CCNT_W-1:0] rem;
   logic [STEP_W-1:0] step;
   logic              cmp_ld;

   assign cmp_ld = cmp0_hit && cfg.rst_en;

   tsc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CCNT_W(CCNT_W), .INC_RST(INC_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cfg(cfg), .period(period),
      .rst_val(rst_val), .comp_ld(comp_ld), .comp_val(comp_val), .ovf_clr(ovf_clr),
      .cnt(cnt), .ovf(ovf), .rem(rem)
   );

   tsc_comp #(.CCNT_W(CCNT_W), .SLOW_EN(SLOW_EN)) u_comp (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .period(period), .comp_ld(comp_ld),
      .comp_val(comp_val), .step(step), .rem(rem)
   );

   tsc_core #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_core (
      .clk(clk), .rst_n(rst_n), .step(step), .load(cmp_ld), .load_val(rst_val),
      .ovf_clr(ovf_clr), .cnt(cnt), .ovf(ovf)
   );
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk #(
   parameter int CNT_W  = 64,
   parameter int CCNT_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  cnt,
   input logic              ovf,
   input logic [CCNT_W-1:0] rem,
   input logic              cmp_ld,
   input logic              comp_ld,
   input logic              ovf_clr,
   input logic [CNT_W-1:0]  rst_val,
   input logic [3:0]        cinc_m1,
   input logic              slow
);
   // R2
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(cmp_ld) && cnt >= $past(cnt)) |->
         ((cnt - $past(cnt)) >= CNT_W'(1) && (cnt - $past(cnt)) <= CNT_W'(16)));

   // R3
   comp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(cmp_ld) && !$past(slow) && $past(rem) != '0 &&
       cnt >= $past(cnt)) |->
         ((cnt - $past(cnt)) == CNT_W'($past(cinc_m1)) + CNT_W'(1)));

   // R4
   rem_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(comp_ld)) |->
         (rem == $past(rem) || rem == $past(rem) - CCNT_W'(1)));

   // R4
   rem_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(comp_ld) && $past(rem) == '0) |-> (rem == '0));

   // R6
   wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(cmp_ld) && cnt < $past(cnt)) |-> ovf);

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ovf) && !$past(ovf_clr)) |-> ovf);

   // R8
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cmp_ld)) |-> (cnt == $past(rst_val)));
endmodule

bind tsc_counter tsc_chk #(.CNT_W(CNT_W), .CCNT_W(CCNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt), .ovf(ovf), .rem(rem), .cmp_ld(cmp_ld),
   .comp_ld(comp_ld), .ovf_clr(ovf_clr), .rst_val(rst_val),
   .cinc_m1(cfg.cinc_m1), .slow(cfg.slow)
);

// File: tb/tb_tsc_counter.sv
`timescale 1ns/1ps
module tb_tsc_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        cmp0_hit = 1'b0;
   logic [63:0] cnt;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   tsc_counter dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cmp0_hit(cmp0_hit), .cnt(cnt)
   );

   typedef struct packed {
      logic [4:0]  inc;
      logic [4:0]  cinc;
      logic        slow;
      logic [7:0]  per;
      logic [23:0] cc;
      logic [7:0]  edges;
      logic [15:0] delta;
      logic [23:0] rem;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{5'd5,  5'd1,  1'b0, 8'd0, 24'd0,  8'd10, 16'd50, 24'd0},  // R2
      '{5'd1,  5'd16, 1'b0, 8'd0, 24'd4,  8'd10, 16'd70, 24'd0},  // R3 R4
      '{5'd16, 5'd1,  1'b0, 8'd0, 24'd20, 8'd8,  16'd8,  24'd12}, // R3
      '{5'd2,  5'd10, 1'b1, 8'd3, 24'd2,  8'd9,  16'd34, 24'd0},  // R5
      '{5'd4,  5'd1,  1'b1, 8'd4, 24'd5,  8'd10, 16'd34, 24'd3},  // R5
      '{5'd3,  5'd7,  1'b1, 8'd1, 24'd3,  8'd5,  16'd27, 24'd0},  // R5
      '{5'd16, 5'd16, 1'b0, 8'd0, 24'd0,  8'd3,  16'd48, 24'd0}   // R2
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic hit();
      cmp0_hit = 1'b1;
      @(negedge clk);
      cmp0_hit = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [31:0] d, d2;
      logic [63:0] c0;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(3'd0, d); check("R1 cfg", 64'(d), 64'h4);
      rd(3'd1, d); check("R1 remaining", 64'(d), 64'h0);
      rd(3'd3, d); check("R1 overflow", 64'(d), 64'h0);
      check("R1 count", cnt, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      c0 = cnt;
      repeat (4) @(negedge clk);
      check("R2 default step", cnt - c0, 64'd20);

      for (int i = 0; i < NV; i++) begin
         wr(3'd0, {22'd0, 1'b0, VECS[i].slow, 4'(VECS[i].cinc - 5'd1), 4'(VECS[i].inc - 5'd1)});
         wr(3'd2, {24'd0, VECS[i].per});
         wr(3'd1, {8'd0, VECS[i].cc});
         c0 = cnt;
         repeat (int'(VECS[i].edges)) @(negedge clk);
         check($sformatf("R3/R5 vector %0d delta", i), cnt - c0, 64'(VECS[i].delta));
         rd(3'd1, d);
         check($sformatf("R4 vector %0d remaining", i), 64'(d), 64'(VECS[i].rem));
      end

      // R8 restart load, R9 count readback
      wr(3'd4, 32'hFFFF_FFFD);
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd0, 32'h0000_0204);
      hit();
      check("R8 restart value", cnt, 64'hFFFF_FFFF_FFFF_FFFD);
      rd(3'd6, d); rd(3'd7, d2);
      check("R9 count halves", {d2, d}, 64'hFFFF_FFFF_FFFF_FFFD);
      @(negedge clk);
      // R6 wrap sets overflow
      check("R6 wrapped count", cnt, 64'd2);
      rd(3'd3, d); check("R6 overflow set", 64'(d), 64'h1);
      // R7 write of zero ignored, write of one clears
      wr(3'd3, 32'h0);
      rd(3'd3, d); check("R7 zero write keeps flag", 64'(d), 64'h1);
      wr(3'd3, 32'h1);
      rd(3'd3, d); check("R7 one write clears", 64'(d), 64'h0);
      // R7 wrap on the same edge as a clear keeps the flag
      hit();
      wr(3'd3, 32'h1);
      rd(3'd3, d); check("R7 wrap beats clear", 64'(d), 64'h1);
      check("R6 second wrap", cnt, 64'd2);
      wr(3'd3, 32'h1);
      // R8 hit ignored with restart disabled
      wr(3'd0, 32'h0000_0004);
      c0 = cnt;
      hit();
      check("R8 hit ignored", cnt - c0, 64'd5);
      rd(3'd3, d); check("R8 no overflow", 64'(d), 64'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule